// File: doc/BRIEF.md
# Ethernet link status supervisor

This block sits next to an Ethernet MAC and turns raw health indications from the clocking, the transmit lanes and the receive PCS into three qualified outputs: a local fault flag, a remote fault flag and a transmit-ready strobe level. Every status input is treated as asynchronous. Each one passes through a multi-flop synchronizer into the MAC clock domain before any decision uses it.

A static mode input chooses how link faults are handled. In bidirectional mode the transmitter is held off until the local receive path is aligned and the link partner has stopped signalling remote fault. In unidirectional mode the fault flags are still computed and reported, but the transmitter does not wait for them. When fault handling is off, both flags read low. A separate PCS-only input also releases the transmitter from any dependence on receive status. The remote fault flag clears only after the partner's "no remote fault" condition has held for a programmable number of consecutive cycles, so short glitches do not release it.

Top module: `eth_link_supervisor`

## Requirements
- R1: While the synchronized PLL-lock input is low, `tx_ready_o` is low and both fault flags hold their asserted reset value. The exception is mode off, where the flags read low.
- R2: While the synchronized TX-lanes-stable input is low, the outputs behave as in R1.
- R3: During and after reset in bidirectional mode, `local_fault_o` and `remote_fault_o` are high and `tx_ready_o` is low until the clearing conditions are met.
- R4: The local fault flag clears only after the synchronized RX-aligned input is high while high-BER is low and the link is qualified.
- R5: The remote fault flag clears only after the synchronized remote-fault input has been low for `RF_CLEAR_CYCLES` consecutive qualified cycles. Any high cycle, or any loss of qualification, restarts the count and re-asserts the flag.
- R6: With `lf_mode_i` = 2'b10 (bidirectional) and `pcs_only_i` low, `tx_ready_o` is high only when both fault flags are low.
- R7: With `lf_mode_i` = 2'b01 (unidirectional), 2'b00 or 2'b11 (off), or with `pcs_only_i` high, `tx_ready_o` follows PLL lock AND lanes stable, regardless of RX status.
- R8: In unidirectional mode, the fault flags are computed and reported exactly as in bidirectional mode, but they do not affect `tx_ready_o`.
- R9: A synchronized high-BER or loss of RX alignment re-asserts the local fault flag on the next clock edge. In gated bidirectional mode, `tx_ready_o` drops on that same edge.
- R10: With fault handling off (`lf_mode_i` 2'b00 or 2'b11), both fault outputs are low at all times, including reset.
- R11: Each status input reaches the outputs through `SYNC_STAGES` synchronizer flops plus one output register. With the default of 2 stages, an input change sampled at a clock edge shows on the outputs after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MAC clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_locked_i | input | 1 | PLL lock, asynchronous |
| tx_lanes_stable_i | input | 1 | Transmit lanes stable, asynchronous |
| rx_pcs_aligned_i | input | 1 | Receive PCS aligned and ready, asynchronous |
| rx_hi_ber_i | input | 1 | Receive high bit-error-rate state, asynchronous |
| rx_remote_fault_i | input | 1 | Partner is signalling remote fault, asynchronous |
| lf_mode_i | input | 2 | Fault handling: 00 off, 01 unidirectional, 10 bidirectional, 11 off |
| pcs_only_i | input | 1 | PCS-only operation: TX ready ignores RX status |
| local_fault_o | output | 1 | Qualified local fault flag |
| remote_fault_o | output | 1 | Qualified remote fault flag |
| tx_ready_o | output | 1 | Transmit path may send data |

## Verification
The assertions assume that `lf_mode_i` and `pcs_only_i` are static between resets and change only while `rst_n` is low. They also assume each asynchronous input holds a new level long enough for the synchronizer to capture it. The bench meets both assumptions. It changes the mode inputs only inside its reset task. It drives every status input on the falling clock edge and holds each level for at least several cycles, apart from the deliberate short low pulses on the remote-fault input, which test the glitch filter.

// File: rtl/els_pkg.sv
package els_pkg;

   typedef enum logic [1:0] {
      LF_OFF    = 2'b00,
      LF_UNIDIR = 2'b01,
      LF_BIDIR  = 2'b10,
      LF_RSVD   = 2'b11
   } lf_mode_e;

   localparam int unsigned N_STATUS = 5;
   localparam int unsigned IDX_PLL  = 0;
   localparam int unsigned IDX_LANE = 1;
   localparam int unsigned IDX_ALGN = 2;
   localparam int unsigned IDX_HBER = 3;
   localparam int unsigned IDX_RFLT = 4;

endpackage

// File: rtl/els_sync.sv
module els_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("els_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("els_sync: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain <= '0;
         end else begin
            chain <= {chain[STAGES-2:0], d_i[i]};
         end
      end

      assign q_o[i] = chain[STAGES-1];
   end

endmodule

// File: rtl/els_local_fault.sv
module els_local_fault (
   input  logic clk,
   input  logic rst_n,
   input  logic qual_i,
   input  logic aligned_i,
   input  logic hi_ber_i,
   output logic lf_next_o,
   output logic lf_q_o
);

   logic healthy;

   always_comb begin
      healthy   = qual_i && aligned_i && !hi_ber_i;
      lf_next_o = !healthy;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lf_q_o <= 1'b1;
      end else begin
         lf_q_o <= lf_next_o;
      end
   end

   // R4: local fault falls only after a healthy, qualified cycle
   p_lf_clear_needs_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lf_q_o) |-> $past(qual_i && aligned_i && !hi_ber_i));

   // R9: high BER re-asserts local fault on the next edge
   p_hiber_sets_lf_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hi_ber_i |=> lf_q_o);

   // R9: loss of alignment re-asserts local fault on the next edge
   p_unalign_sets_lf_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !aligned_i |=> lf_q_o);

endmodule

// File: rtl/els_persist_filter.sv
module els_persist_filter #(
   parameter int unsigned RF_CLEAR_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic qual_i,
   input  logic rf_in_i,
   output logic rf_next_o,
   output logic rf_q_o
);

   localparam int unsigned CNT_W = $clog2(RF_CLEAR_CYCLES + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RF_CLEAR_CYCLES);

   if (RF_CLEAR_CYCLES < 1) begin : g_bad_limit
      $error("els_persist_filter: RF_CLEAR_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_next;
   logic             restart;

   always_comb begin
      restart = !qual_i || rf_in_i;
      if (restart) begin
         cnt_next = '0;
      end else if (cnt_q == LIMIT) begin
         cnt_next = cnt_q;
      end else begin
         cnt_next = cnt_q + 1'b1;
      end
      rf_next_o = (cnt_next != LIMIT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rf_q_o <= 1'b1;
      end else begin
         cnt_q  <= cnt_next;
         rf_q_o <= rf_next_o;
      end
   end

   // R5: counter never runs past its limit
   p_cnt_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIMIT);

   // R5: a remote-fault cycle or loss of qualification re-asserts the flag
   p_rf_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_in_i || !qual_i) |=> rf_q_o);

   // R5: flag falls only after a clean, qualified cycle
   p_rf_clear_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rf_q_o) |-> $past(qual_i && !rf_in_i));

endmodule

// File: rtl/eth_link_supervisor.sv
module eth_link_supervisor
   import els_pkg::*;
#(
   parameter int unsigned SYNC_STAGES     = 2,
   parameter int unsigned RF_CLEAR_CYCLES = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pll_locked_i,
   input  logic       tx_lanes_stable_i,
   input  logic       rx_pcs_aligned_i,
   input  logic       rx_hi_ber_i,
   input  logic       rx_remote_fault_i,
   input  logic [1:0] lf_mode_i,
   input  logic       pcs_only_i,
   output logic       local_fault_o,
   output logic       remote_fault_o,
   output logic       tx_ready_o
);

   logic [N_STATUS-1:0] raw;
   logic [N_STATUS-1:0] syn;
   logic                pll_s;
   logic                lane_s;
   logic                qual_s;
   logic                lf_next;
   logic                lf_q;
   logic                rf_next;
   logic                rf_q;
   logic                tx_ready_q;
   logic                flags_on;
   logic                gate_tx;
   lf_mode_e            mode;

   assign raw[IDX_PLL]  = pll_locked_i;
   assign raw[IDX_LANE] = tx_lanes_stable_i;
   assign raw[IDX_ALGN] = rx_pcs_aligned_i;
   assign raw[IDX_HBER] = rx_hi_ber_i;
   assign raw[IDX_RFLT] = rx_remote_fault_i;

   els_sync #(
      .WIDTH  (N_STATUS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw),
      .q_o   (syn)
   );

   assign pll_s  = syn[IDX_PLL];
   assign lane_s = syn[IDX_LANE];
   assign qual_s = pll_s && lane_s;

   els_local_fault u_local (
      .clk       (clk),
      .rst_n     (rst_n),
      .qual_i    (qual_s),
      .aligned_i (syn[IDX_ALGN]),
      .hi_ber_i  (syn[IDX_HBER]),
      .lf_next_o (lf_next),
      .lf_q_o    (lf_q)
   );

   els_persist_filter #(
      .RF_CLEAR_CYCLES (RF_CLEAR_CYCLES)
   ) u_remote (
      .clk       (clk),
      .rst_n     (rst_n),
      .qual_i    (qual_s),
      .rf_in_i   (syn[IDX_RFLT]),
      .rf_next_o (rf_next),
      .rf_q_o    (rf_q)
   );

   always_comb begin
      mode = lf_mode_e'(lf_mode_i);
      case (mode)
         LF_BIDIR: begin
            flags_on = 1'b1;
            gate_tx  = !pcs_only_i;
         end
         LF_UNIDIR: begin
            flags_on = 1'b1;
            gate_tx  = 1'b0;
         end
         default: begin
            flags_on = 1'b0;
            gate_tx  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_ready_q <= 1'b0;
      end else if (gate_tx) begin
         tx_ready_q <= qual_s && !lf_next && !rf_next;
      end else begin
         tx_ready_q <= qual_s;
      end
   end

   assign local_fault_o  = flags_on && lf_q;
   assign remote_fault_o = flags_on && rf_q;
   assign tx_ready_o     = tx_ready_q;

   // R1: lost PLL lock forces TX ready low and both flags to reset value
   p_pll_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_s |=> (!tx_ready_o && lf_q && rf_q));

   // R2: unstable lanes force TX ready low and both flags to reset value
   p_lane_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_s |=> (!tx_ready_o && lf_q && rf_q));

   // R6: gated mode never reports ready with a fault outstanding
   p_bidir_ready_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_tx && tx_ready_o) |-> (!local_fault_o && !remote_fault_o));

   // R7: ungated modes follow link qualification only
   p_ungated_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_tx && qual_s && $stable(gate_tx)) |=> tx_ready_o);

   // R8: unidirectional mode still reports the internal flags
   p_uni_reports_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LF_UNIDIR) |-> (local_fault_o == lf_q && remote_fault_o == rf_q));

   // R9: in gated mode a local fault and TX ready never coexist
   p_lf_drops_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_tx && lf_q) |-> !tx_ready_o);

   // R10: off modes keep both flags low
   p_off_flags_low_r10: assert property (@(posedge clk)
      (lf_mode_i == 2'b00 || lf_mode_i == 2'b11) |-> (!local_fault_o && !remote_fault_o));

endmodule

// File: tb/eth_link_supervisor_tb.sv
module eth_link_supervisor_tb;

   localparam int unsigned RFC = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pll = 1'b0;
   logic       lanes = 1'b0;
   logic       aligned = 1'b0;
   logic       hiber = 1'b0;
   logic       rflt = 1'b1;
   logic [1:0] mode = 2'b10;
   logic       pcs_only = 1'b0;
   logic       lf_o;
   logic       rf_o;
   logic       tx_o;

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   bit          finished = 1'b0;

   always #4 clk = ~clk;

   eth_link_supervisor #(
      .SYNC_STAGES     (2),
      .RF_CLEAR_CYCLES (RFC)
   ) u_dut (
      .clk               (clk),
      .rst_n             (rst_n),
      .pll_locked_i      (pll),
      .tx_lanes_stable_i (lanes),
      .rx_pcs_aligned_i  (aligned),
      .rx_hi_ber_i       (hiber),
      .rx_remote_fault_i (rflt),
      .lf_mode_i         (mode),
      .pcs_only_i        (pcs_only),
      .local_fault_o     (lf_o),
      .remote_fault_o    (rf_o),
      .tx_ready_o        (tx_o)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic chk3(input string req, input logic lf, input logic rf, input logic tx);
      chk(req, "local_fault", lf_o, lf);
      chk(req, "remote_fault", rf_o, rf);
      chk(req, "tx_ready", tx_o, tx);
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset(input logic [1:0] m, input logic po);
      @(negedge clk);
      rst_n    = 1'b0;
      mode     = m;
      pcs_only = po;
      pll      = 1'b1;
      lanes    = 1'b1;
      aligned  = 1'b0;
      hiber    = 1'b0;
      rflt     = 1'b1;
      edges(3);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R3 R4 R5 R6 R11: bidirectional bring-up
   task automatic t_bidir_bringup();
      do_reset(2'b10, 1'b0);
      chk3("R3", 1'b1, 1'b1, 1'b0);
      edges(10);
      chk3("R3", 1'b1, 1'b1, 1'b0);
      @(negedge clk) aligned = 1'b1;
      edges(2);
      chk("R11", "local_fault latency", lf_o, 1'b1);
      edges(1);
      chk("R4", "local_fault cleared", lf_o, 1'b0);
      chk("R6", "tx waits for remote", tx_o, 1'b0);
      @(negedge clk) rflt = 1'b0;
      edges(RFC + 1);
      chk("R5", "remote held before limit", rf_o, 1'b1);
      chk("R6", "tx held before remote clears", tx_o, 1'b0);
      edges(1);
      chk("R5", "remote cleared at limit", rf_o, 1'b0);
      chk("R6", "tx ready after both clear", tx_o, 1'b1);
   endtask

   // R5: short clean window does not clear remote fault
   task automatic t_glitch();
      @(negedge clk) rflt = 1'b1;
      edges(3);
      chk("R5", "remote re-asserted", rf_o, 1'b1);
      chk("R6", "tx dropped with remote", tx_o, 1'b0);
      @(negedge clk) rflt = 1'b0;
      edges(4);
      @(negedge clk) rflt = 1'b1;
      edges(12);
      chk("R5", "glitch filtered", rf_o, 1'b1);
      @(negedge clk) rflt = 1'b0;
      edges(RFC + 2);
      chk("R5", "remote clears after full window", rf_o, 1'b0);
      chk("R6", "tx back", tx_o, 1'b1);
   endtask

   // R9: high BER and alignment loss
   task automatic t_hiber();
      @(negedge clk) hiber = 1'b1;
      edges(2);
      chk("R11", "hiber not yet seen", lf_o, 1'b0);
      edges(1);
      chk3("R9", 1'b1, 1'b0, 1'b0);
      @(negedge clk) hiber = 1'b0;
      edges(3);
      chk3("R9", 1'b0, 1'b0, 1'b1);
      @(negedge clk) aligned = 1'b0;
      edges(3);
      chk3("R9", 1'b1, 1'b0, 1'b0);
      @(negedge clk) aligned = 1'b1;
      edges(3);
      chk("R4", "realigned", lf_o, 1'b0);
   endtask

   // R2 and R1: lane and PLL loss
   task automatic t_qual_loss();
      @(negedge clk) lanes = 1'b0;
      edges(2);
      chk("R11", "lanes latency", tx_o, 1'b1);
      edges(1);
      chk3("R2", 1'b1, 1'b1, 1'b0);
      @(negedge clk) lanes = 1'b1;
      edges(3);
      chk("R5", "remote restarts after lanes", rf_o, 1'b1);
      edges(RFC);
      chk3("R2", 1'b0, 1'b0, 1'b1);
      @(negedge clk) pll = 1'b0;
      edges(3);
      chk3("R1", 1'b1, 1'b1, 1'b0);
      @(negedge clk) pll = 1'b1;
      edges(RFC + 4);
      chk3("R1", 1'b0, 1'b0, 1'b1);
   endtask

   // R7 R8: unidirectional mode
   task automatic t_unidir();
      do_reset(2'b01, 1'b0);
      edges(2);
      chk("R11", "tx latency after reset", tx_o, 1'b0);
      edges(1);
      chk3("R8", 1'b1, 1'b1, 1'b1);
      @(negedge clk) aligned = 1'b1;
      edges(3);
      chk("R8", "local clears in uni", lf_o, 1'b0);
      @(negedge clk) hiber = 1'b1;
      edges(3);
      chk("R8", "local reported in uni", lf_o, 1'b1);
      chk("R7", "tx not gated in uni", tx_o, 1'b1);
      @(negedge clk) lanes = 1'b0;
      edges(3);
      chk("R7", "tx follows lanes in uni", tx_o, 1'b0);
   endtask

   // R7: PCS-only in bidirectional mode
   task automatic t_pcs_only();
      do_reset(2'b10, 1'b1);
      edges(3);
      chk3("R7", 1'b1, 1'b1, 1'b1);
   endtask

   // R10: fault handling off
   task automatic t_off();
      do_reset(2'b00, 1'b0);
      chk("R10", "local low in reset", lf_o, 1'b0);
      chk("R10", "remote low in reset", rf_o, 1'b0);
      edges(3);
      chk3("R10", 1'b0, 1'b0, 1'b1);
      @(negedge clk) pll = 1'b0;
      edges(3);
      chk3("R10", 1'b0, 1'b0, 1'b0);
      do_reset(2'b11, 1'b0);
      edges(3);
      chk3("R10", 1'b0, 1'b0, 1'b1);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      t_bidir_bringup();
      t_glitch();
      t_hiber();
      t_qual_loss();
      t_unidir();
      t_pcs_only();
      t_off();
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

endmodule